// File: doc/BRIEF.md
# Packed BCD Decimal Adjust Unit

This unit repairs an 8-bit value produced by a plain binary addition of two packed BCD bytes. It turns that value back into a valid two-digit BCD result. It takes three inputs from the adder stage: the raw byte, the carry out of bit 3 (the half carry) and the carry out of bit 7. It decides for each digit whether to add 6, applies the whole correction in one step, and returns the corrected byte with a decimal carry and zero, sign and even-parity flags.

The unit is a single registered stage. A value presented with `in_valid` high appears on the outputs one clock later, with `out_valid` high. While `in_valid` is low, the output registers keep their contents. A carry that is already set on entry is never cleared, so sums above 99 keep their hundreds digit.

Top module: `bcd_adjust`

## Requirements
- R1: The low digit is corrected by +6 when `acc_in[3:0]` is greater than 9 or `aux_cy_in` is 1; otherwise the low digit gets no correction.
- R2: The high digit is corrected by +6 (that is, 60h is added) when `cy_in` is 1, or `acc_in[7:4]` is greater than 9, or `acc_in[7:4]` equals 9 and `acc_in[3:0]` is greater than 9. In the last case the low correction carries into a high digit of 9.
- R3: When both corrections apply, 66h is added in total, and `res` is that sum modulo 256.
- R4: `cy_out` is 1 whenever `cy_in` was 1 for that input. An incoming carry is never cleared.
- R5: `cy_out` is 1 exactly when the high correction was applied. When `cy_in` is 0 and the R2 conditions are false, `cy_out` is 0.
- R6: `zero` is 1 exactly when `res` is 00h.
- R7: `sign` equals bit 7 of `res`.
- R8: `parity` is 1 when `res` holds an even number of 1 bits, and 0 when the count is odd.
- R9: The outputs show the adjustment of the inputs sampled at the previous rising edge with `in_valid` high, and `out_valid` is 1 in that cycle. After a cycle with `in_valid` low, `out_valid` is 0 and `res` and all flags keep their values.
- R10: While `rst_n` is low, and after it until the first valid input, `out_valid`, `res`, `cy_out`, `zero`, `sign` and `parity` are all 0.
- R11: For any two valid BCD bytes added in binary with carry-in 0, `res` is the BCD encoding of their decimal sum modulo 100, and `cy_out` is 1 exactly when that sum is 100 or more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Inputs are valid this cycle |
| acc_in | input | 8 | Raw binary sum to adjust |
| aux_cy_in | input | 1 | Carry out of bit 3 from the addition |
| cy_in | input | 1 | Carry out of bit 7 from the addition |
| out_valid | output | 1 | Outputs hold a new result |
| res | output | 8 | Adjusted packed BCD byte |
| cy_out | output | 1 | Decimal carry (hundreds digit) |
| zero | output | 1 | Result is zero |
| sign | output | 1 | Bit 7 of the result |
| parity | output | 1 | Result has even parity |

## Verification
The bench adds every pair of two-digit BCD operands and compares the result with a decimal reference. This catches a design that tests only the digit values and ignores the half carry: it would leave sums such as 09+09=12h uncorrected. Directed cases put a high digit of 9 next to a low digit above 9 (9Ah, 9Fh). A design that decides the high correction before the low carry ripples in would return A0h-style non-BCD bytes there. Inputs with `cy_in` set and small digits check that the carry is kept set and that 60h is still added. A design that recomputes the carry from the corrected byte alone would drop hundreds. Wraps such as 9Ah→00h exercise the zero flag. Gaps in `in_valid` show whether the result registers wrongly reload.

// File: rtl/bcd_adjust.sv
module bcd_adjust (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic [7:0] acc_in,
  input  logic       aux_cy_in,
  input  logic       cy_in,
  output logic       out_valid,
  output logic [7:0] res,
  output logic       cy_out,
  output logic       zero,
  output logic       sign,
  output logic       parity
);
  logic       lo_fix;
  logic       hi_fix;
  logic [7:0] corr;
  logic [7:0] adj;

  assign lo_fix = aux_cy_in | (acc_in[3:0] > 4'd9);
  assign hi_fix = cy_in | (acc_in[7:4] > 4'd9) |
                  ((acc_in[7:4] == 4'd9) & (acc_in[3:0] > 4'd9));
  assign corr   = {1'b0, hi_fix, hi_fix, 1'b0, 1'b0, lo_fix, lo_fix, 1'b0};
  assign adj    = acc_in + corr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      res       <= 8'h00;
      cy_out    <= 1'b0;
      zero      <= 1'b0;
      sign      <= 1'b0;
      parity    <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        res    <= adj;
        cy_out <= hi_fix;
        zero   <= (adj == 8'h00);
        sign   <= adj[7];
        parity <= ~^adj;
      end
    end
  end
endmodule

// File: rtl/bcd_adjust_chk.sv
module bcd_adjust_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic [7:0] acc_in,
  input logic       aux_cy_in,
  input logic       cy_in,
  input logic       out_valid,
  input logic [7:0] res,
  input logic       cy_out,
  input logic       zero,
  input logic       sign,
  input logic       parity
);
  // R4
  carry_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cy_in) |=> cy_out);

  // R1
  low_fix_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && aux_cy_in && !cy_in && acc_in[7:4] < 4'd9 && acc_in[3:0] < 4'd10)
    |=> (res == $past(acc_in) + 8'h06) && !cy_out);

  // R9
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(res) && $stable(cy_out)));

  // R6
  zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (zero == (res == 8'h00)));

  // R7
  sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (sign == res[7]));

  // R8
  parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (parity == ($countones(res) % 2 == 0)));
endmodule

bind bcd_adjust bcd_adjust_chk u_chk (.*);

// File: tb/bcd_adjust_tb.sv
module bcd_adjust_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] acc_in = 8'h00;
  logic       aux_cy_in = 1'b0;
  logic       cy_in = 1'b0;
  logic       out_valid;
  logic [7:0] res;
  logic       cy_out, zero, sign, parity;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  bcd_adjust u_dut (.*);

  function automatic logic [8:0] ref_adj(input logic [7:0] a, input logic ac, input logic cy);
    logic       lo, hi;
    logic [8:0] t;
    lo = ac || (a[3:0] > 4'd9);
    t  = {1'b0, a} + (lo ? 9'h006 : 9'h000);
    hi = cy || (a > 8'h99);
    t  = t + (hi ? 9'h060 : 9'h000);
    return {hi, t[7:0]};
  endfunction

  function automatic logic [7:0] to_bcd(input int v);
    return 8'((v / 10) * 16 + (v % 10));
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [7:0] a, input logic ac, input logic cy);
    @(negedge clk);
    in_valid = 1'b1; acc_in = a; aux_cy_in = ac; cy_in = cy;
    @(negedge clk);
  endtask

  task automatic check_ref(input logic [7:0] a, input logic ac, input logic cy);
    logic [8:0] e;
    e = ref_adj(a, ac, cy);
    apply(a, ac, cy);
    chk("R3 res", res, e[7:0]);
    chk("R5 cy_out", cy_out, e[8]);
    chk("R6 zero", zero, e[7:0] == 8'h00);
    chk("R7 sign", sign, e[7]);
    chk("R8 parity", parity, ~^e[7:0]);
    chk("R9 out_valid", out_valid, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 out_valid", out_valid, 0);
    chk("R10 res", res, 0);
    chk("R10 flags", {cy_out, zero, sign, parity}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 idle", {out_valid, res}, 0);

    // R1 directed: half carry alone, and digit above 9
    apply(8'h12, 1'b1, 1'b0); chk("R1 ac", res, 8'h18); chk("R5 ac no carry", cy_out, 0);
    apply(8'h4D, 1'b0, 1'b0); chk("R1 digit", res, 8'h53);
    // R2 directed: high digit 9 next to low above 9
    apply(8'h9A, 1'b0, 1'b0); chk("R2 9A res", res, 8'h00); chk("R2 9A cy", cy_out, 1);
    chk("R6 zero wrap", zero, 1);
    apply(8'h9F, 1'b0, 1'b0); chk("R2 9F res", res, 8'h05);
    apply(8'hA0, 1'b0, 1'b0); chk("R2 A0 res", res, 8'h00);
    // R3 both corrections
    apply(8'h12, 1'b1, 1'b1); chk("R3 66h", res, 8'h78);
    // R4 carry kept
    apply(8'h32, 1'b1, 1'b1); chk("R4 res", res, 8'h98); chk("R4 cy", cy_out, 1);
    apply(8'h00, 1'b0, 1'b1); chk("R4 zero digits", res, 8'h60); chk("R4 cy0", cy_out, 1);
    // R8 parity odd
    apply(8'h01, 1'b0, 1'b0); chk("R8 odd", parity, 0); chk("R7 pos", sign, 0);

    // R9 hold while idle
    @(negedge clk);
    in_valid = 1'b0; acc_in = 8'hFF; aux_cy_in = 1'b1; cy_in = 1'b1;
    @(negedge clk);
    chk("R9 no valid", out_valid, 0);
    chk("R9 hold res", res, 8'h01);
    chk("R9 hold cy", cy_out, 0);

    // R11 exhaustive decimal check
    for (int x = 0; x < 100; x++) begin
      for (int y = 0; y < 100; y++) begin
        logic [7:0] a, b;
        logic [8:0] s;
        logic       h;
        a = to_bcd(x); b = to_bcd(y);
        s = {1'b0, a} + {1'b0, b};
        h = ({1'b0, a[3:0]} + {1'b0, b[3:0]}) > 5'd15;
        apply(s[7:0], h, s[8]);
        chk("R11 sum", res, to_bcd((x + y) % 100));
        chk("R11 carry", cy_out, (x + y) >= 100);
      end
    end

    // R1 R2 R3 random inputs against reference
    for (int k = 0; k < 3000; k++) begin
      logic [31:0] r;
      r = $urandom;
      check_ref(r[7:0], r[8], r[9]);
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule